// File: doc/BRIEF.md
# Prescaled Reload Timer

This block is a 16-bit counter that climbs from zero to a programmable ceiling, falls back to zero and raises an update pulse each time it does so. Its clock is thinned out by a divider whose ratio is a power of two chosen by a 4-bit exponent, so the count can step on every clock or as rarely as once in 32768 clocks.

Software programs it through a plain synchronous write port with four word addresses. The divider exponent is always held in a staging copy and reaches the live divider only on an update. The ceiling is staged the same way only when a control bit asks for it. Updates come from a wrap or from a software strobe. Wraps can be kept from producing updates, and a sticky flag records updates for software, which clears it by writing 1.

Top module: `upcnt_timer`

## Requirements
- R1: After reset, count_o is 0, update_o and flag_o are 0, the live ceiling is 0xFFFF, the live exponent is 0 and every control bit is 0.
- R2: Address 0 holds the control bits: bit 0 run, bit 1 update mute, bit 2 flag-source select, bit 3 ceiling staging. A run bit captured at clock edge E moves the count for the first time at edge E+2, because the internal run enable follows the bit one cycle late.
- R3: With live exponent e, taken from bits [3:0] of address 1, and run enabled, the count advances once every 2^e clocks.
- R4: A write to address 1 changes only the staged exponent; the live divider keeps its old ratio until the next update.
- R5: On a divider step with the count equal to the live ceiling, the count returns to 0; when mute is 0, update_o is 1 for exactly the cycle in which count_o first shows that 0.
- R6: A write to address 2 with staging 0 changes the live ceiling at once; with staging 1 it changes only the staged ceiling, which is copied to the live ceiling on the next update.
- R7: While mute is 1 a wrap produces no update pulse, sets no flag and copies no staged value.
- R8: Writing address 3 with bit 0 set forces an update whatever mute says: count and divider restart from 0, staged values are copied, the live ratio in force before the copy is not otherwise altered.
- R9: A wrap update always sets flag_o; a forced update sets it only while the flag-source select bit is 0.
- R10: Writing address 3 with bit 1 set clears flag_o; a setting event in the same cycle wins over the clear.
- R11: With the run bit 0 the count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Word address of the write |
| wr_data | input | 16 | Write data |
| count_o | output | 16 | Current count |
| update_o | output | 1 | One-cycle update pulse |
| flag_o | output | 1 | Sticky update flag |

## Verification
The count is driven with a divide-by-one ratio, then a divide-by-four ratio reached through a staged exponent, so that a timer ignoring the staging or applying it late shows a different step rhythm. The ceiling is rewritten both directly and through staging, and wraps are run with updates muted and unmuted, which separates a live copy taken too early from one taken too late. Forced updates are issued under both flag-source settings and together with a flag clear, which tells apart the flag's set priority and its source selection.

// File: rtl/upt_pkg.sv
package upt_pkg;
    localparam int CW = 16;
    localparam int EW = 4;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_EXP  = 2'd1;
    localparam logic [1:0] A_CEIL = 2'd2;
    localparam logic [1:0] A_EVT  = 2'd3;

    typedef struct packed {
        logic stage;
        logic fsel;
        logic mute;
        logic run;
    } ctrl_t;
endpackage

// File: rtl/upt_prescaler.sv
module upt_prescaler #(
    parameter int PW = 16,
    parameter int EW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          restart,
    input  logic [EW-1:0] expo,
    output logic          tick
);
    typedef struct packed {
        logic [PW-1:0] pcnt;
    } st_t;

    st_t st_d, st_q;
    logic [PW-1:0] lim;

    always_comb begin
        lim  = (PW'(1) << expo) - PW'(1);
        tick = run && !restart && (st_q.pcnt == lim);
        st_d = st_q;
        if (restart)
            st_d.pcnt = '0;
        else if (run)
            st_d.pcnt = tick ? '0 : st_q.pcnt + PW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    a_r3_tick_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> run);
    a_r8_div_restart: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> st_q.pcnt == '0);
endmodule

// File: rtl/upt_counter.sv
module upt_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          restart,
    input  logic [CW-1:0] ceil,
    output logic [CW-1:0] cnt,
    output logic          wrap
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        wrap = tick && (st_q.cnt == ceil);
        st_d = st_q;
        if (restart)
            st_d.cnt = '0;
        else if (tick)
            st_d.cnt = wrap ? '0 : st_q.cnt + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;

    a_r5_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> cnt == '0);
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !restart) |=> $stable(cnt));
endmodule

// File: rtl/upcnt_timer.sv
module upcnt_timer
    import upt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [15:0] wr_data,
    output logic [15:0] count_o,
    output logic        update_o,
    output logic        flag_o
);
    localparam int PW = 16;

    typedef struct packed {
        ctrl_t         ctrl;
        logic [EW-1:0] exp_stg;
        logic [EW-1:0] exp_live;
        logic [CW-1:0] ceil_stg;
        logic [CW-1:0] ceil_live;
        logic          run;
        logic          upd;
        logic          flag;
    } st_t;

    st_t st_d, st_q;
    logic tick, wrap, force_upd, clr, upd_now, flag_set;
    logic [CW-1:0] cnt;

    upt_prescaler #(.PW(PW), .EW(EW)) i_div (
        .clk(clk), .rst_n(rst_n), .run(st_q.run), .restart(force_upd),
        .expo(st_q.exp_live), .tick(tick)
    );

    upt_counter #(.CW(CW)) i_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .restart(force_upd),
        .ceil(st_q.ceil_live), .cnt(cnt), .wrap(wrap)
    );

    always_comb begin
        force_upd = wr_en && (wr_addr == A_EVT) && wr_data[0];
        clr       = wr_en && (wr_addr == A_EVT) && wr_data[1];
        upd_now   = (wrap && !st_q.ctrl.mute) || force_upd;
        flag_set  = (wrap && !st_q.ctrl.mute) || (force_upd && !st_q.ctrl.fsel);

        st_d      = st_q;
        st_d.run  = st_q.ctrl.run;
        st_d.upd  = upd_now;

        if (upd_now) begin
            st_d.exp_live  = st_q.exp_stg;
            st_d.ceil_live = st_q.ceil_stg;
        end

        if (wr_en) begin
            case (wr_addr)
                A_CTRL: st_d.ctrl = ctrl_t'(wr_data[3:0]);
                A_EXP:  st_d.exp_stg = wr_data[EW-1:0];
                A_CEIL: begin
                    st_d.ceil_stg = wr_data;
                    if (!st_q.ctrl.stage) st_d.ceil_live = wr_data;
                end
                default: ;
            endcase
        end

        if (flag_set)  st_d.flag = 1'b1;
        else if (clr)  st_d.flag = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.ceil_stg  <= '1;
            st_q.ceil_live <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o  = cnt;
    assign update_o = st_q.upd;
    assign flag_o   = st_q.flag;

    a_r2_run_follows: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ctrl.run |=> st_q.run);
    a_r7_muted_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && st_q.ctrl.mute && !force_upd) |=> !update_o);
    a_r7_muted_keeps_exp: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && st_q.ctrl.mute && !force_upd) |=> $stable(st_q.exp_live));
    a_r8_force_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        force_upd |=> (update_o && count_o == '0));
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        flag_set |=> flag_o);
    a_r4_exp_only_on_update: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_now |=> $stable(st_q.exp_live));
endmodule

// File: tb/test_upcnt_timer.sv
module test_upcnt_timer;
    localparam int TCLK = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] count_o;
    logic        update_o, flag_o;

    int checks = 0;
    int errors = 0;
    string phase = "R1";
    bit    done = 0;

    always #(TCLK/2) clk = ~clk;

    upcnt_timer i_upcnt_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .count_o(count_o), .update_o(update_o), .flag_o(flag_o)
    );

    // behavioural reference
    int m_cnt, m_div, m_ceil, m_ceil_s, m_exp, m_exp_s;
    bit m_run_bit, m_mute, m_fsel, m_stage, m_run, m_upd, m_flag;

    always @(posedge clk) begin
        int  n_cnt, n_div;
        bit  step, wr, frc, clrf, wrp, upd, setf;
        if (!rst_n) begin
            m_cnt = 0; m_div = 0; m_ceil = 65535; m_ceil_s = 65535;
            m_exp = 0; m_exp_s = 0; m_run_bit = 0; m_mute = 0; m_fsel = 0;
            m_stage = 0; m_run = 0; m_upd = 0; m_flag = 0;
        end else begin
            frc  = wr_en && wr_addr == 3 && wr_data[0];
            clrf = wr_en && wr_addr == 3 && wr_data[1];
            step = m_run && !frc && (m_div == (1 << m_exp) - 1);
            wrp  = step && (m_cnt == m_ceil);
            n_cnt = m_cnt; n_div = m_div;
            if (frc) begin n_cnt = 0; n_div = 0; end
            else if (m_run) begin
                n_div = step ? 0 : m_div + 1;
                if (step) n_cnt = wrp ? 0 : (m_cnt + 1) % 65536;
            end
            upd  = (wrp && !m_mute) || frc;
            setf = (wrp && !m_mute) || (frc && !m_fsel);
            m_run = m_run_bit;
            m_upd = upd;
            if (upd) begin m_exp = m_exp_s; m_ceil = m_ceil_s; end
            if (wr_en && wr_addr == 2) begin
                if (!m_stage) m_ceil = wr_data;
                m_ceil_s = wr_data;
            end
            if (wr_en && wr_addr == 1) m_exp_s = wr_data[3:0];
            if (wr_en && wr_addr == 0) begin
                m_run_bit = wr_data[0]; m_mute = wr_data[1];
                m_fsel = wr_data[2]; m_stage = wr_data[3];
            end
            if (setf) m_flag = 1;
            else if (clrf) m_flag = 0;
            m_cnt = n_cnt; m_div = n_div;
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // compare on every clock, away from the edge
    always @(negedge clk) if (rst_n && !done) begin
        chk({phase, " count"}, count_o, m_cnt);
        chk({phase, " update"}, update_o, m_upd);
        chk({phase, " flag"}, flag_o, m_flag);
    end

    task automatic wr(logic [1:0] a, logic [15:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        fork
            begin
                idle(3);
                rst_n = 1;
                idle(2);
                phase = "R1";
                chk("R1 reset count", count_o, 0);
                chk("R1 reset flag", flag_o, 0);
                chk("R1 reset update", update_o, 0);

                phase = "R6";
                wr(2, 16'd5);                 // direct ceiling
                phase = "R2";
                @(negedge clk);
                wr_en = 1; wr_addr = 0; wr_data = 16'h0001;
                @(negedge clk);               // after capture edge E
                wr_en = 0;
                chk("R2 count at E", count_o, 0);
                @(negedge clk);
                chk("R2 count at E+1", count_o, 0);
                @(negedge clk);
                chk("R2 count at E+2", count_o, 1);
                phase = "R5";
                idle(14);
                chk("R5 flag after wraps", flag_o, 1);
                phase = "R10";
                wr(3, 16'h0002);
                chk("R10 cleared", flag_o, m_flag);

                phase = "R4";
                wr(1, 16'd2);
                idle(8);
                phase = "R3";
                idle(30);

                phase = "R6";
                wr(0, 16'h0009);
                wr(2, 16'd9);
                idle(30);

                phase = "R7";
                wr(0, 16'h000B);
                wr(1, 16'd0);
                idle(60);

                phase = "R8";
                wr(3, 16'h0001);
                chk("R8 forced count", count_o, 0);
                idle(20);

                phase = "R9";
                wr(0, 16'h000D);
                wr(3, 16'h0002);
                wr(3, 16'h0001);
                chk("R9 forced no flag", flag_o, 0);
                idle(30);

                phase = "R10";
                wr(0, 16'h0009);
                wr(3, 16'h0003);
                chk("R10 set wins", flag_o, 1);

                phase = "R11";
                wr(0, 16'h0000);
                idle(2);
                begin
                    int held;
                    held = count_o;
                    idle(10);
                    chk("R11 hold", count_o, held);
                end
            end
            begin
                idle(5000);
                errors++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule